// File: doc/BRIEF.md
# Enhanced Parallel Port Cycle Engine

This block sits behind a printer-port register window and turns host accesses to the enhanced-mode address port and data port into byte transfers to a peripheral. A transfer runs only when the port control register holds the exact pattern that belongs to the access direction. In any other control state the access completes on the host side but nothing reaches the peripheral. The block also holds the control register itself and a sticky timeout flag. Any byte the peripheral reports as failed sets the flag, and host software clears it again through the status register.

Host requests use a valid/ready handshake. `host_req_ready` is high only while the engine is idle. A request is taken on the edge where valid and ready are both high. Ready then stays low until the single-cycle response pulse on `host_rsp_valid` has been given, so the host is held back for every byte of a multi-byte access. The host must keep its request fields stable while valid is high and ready is low. Responses have no back-pressure.

On the peripheral side there is one byte per handshake. `periph_req` and its attributes are held until the peripheral raises `periph_done`. `periph_err` qualifies that done.

Top module: `epp_cycle_engine`

## Requirements
- R1: After reset, `host_req_ready` is 1, `timeout_flag` is 0 and the control register holds 0xCC, so a control read returns 0xFFFFFFCC.
- R2: A write to offset 2 stores the low byte with bits 7:6 forced to 1. The result appears on `ctrl_out` and in later control reads, in byte 0 with the other lanes all ones.
- R3: A write to offset 3 (address port) or offset 4 (data port) produces peripheral bytes only when (control & 0x2F) == 0x04. Otherwise no `periph_req` is raised and the write still receives a response.
- R4: A read at offset 3 or 4 runs only when (control & 0x2F) == 0x24. Otherwise it returns 0xFFFFFFFF and no `periph_req` is raised.
- R5: On the data port, size code 0, 1 and 2 means 1, 2 and 4 bytes, and code 3 also means 4. Bytes move least significant first, and read byte k lands in bits 8k+7:8k. The address port always moves one byte, whatever the size code. `periph_addr_cyc` is 1 for address-port bytes and `periph_write` gives the direction.
- R6: A byte finished with `periph_err` high sets `timeout_flag`, which stays set. A status read (offset 1) returns `periph_status[7:1]` with bit 0 replaced by the flag, in byte 0 with the other lanes all ones.
- R7: A status write with bit 0 set clears `timeout_flag`. A status write with bit 0 clear leaves it unchanged.
- R8: A multi-byte transfer stops after its first failing byte. A read then returns the bytes received before the failure, and ones in every lane from the failing byte upward.
- R9: Between acceptance and response `host_req_ready` is 0. Each accepted request gets exactly one `host_rsp_valid` pulse lasting one cycle, after which ready returns to 1. Write responses carry all ones.
- R10: A control write that changes bit 5 pulses `periph_dir_chg` for one cycle, with `periph_dir` showing the new bit 5. A control write that keeps bit 5 gives no pulse.
- R11: While `periph_req` is high and `periph_done` is low, `periph_req`, `periph_wdata` and `periph_write` hold their values into the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_req_valid | input | 1 | Host request present |
| host_req_ready | output | 1 | Engine idle, can take a request |
| host_req_write | input | 1 | 1 = write, 0 = read |
| host_req_offset | input | 3 | Register offset in the port window |
| host_req_size | input | 2 | Access width code (0:1, 1:2, 2/3:4 bytes) |
| host_req_wdata | input | 32 | Write data, byte 0 first on the wire |
| host_rsp_valid | output | 1 | One-cycle response pulse |
| host_rsp_rdata | output | 32 | Read data, unused lanes all ones |
| ctrl_out | output | 8 | Current control register |
| periph_status | input | 8 | Status lines from the peripheral |
| timeout_flag | output | 1 | Sticky transfer-failure flag |
| periph_dir_chg | output | 1 | Pulse: data direction changed |
| periph_dir | output | 1 | Data direction (1 = peripheral to host) |
| periph_req | output | 1 | Byte transfer request |
| periph_write | output | 1 | Byte direction, 1 = host to peripheral |
| periph_addr_cyc | output | 1 | Byte belongs to an address cycle |
| periph_wdata | output | 8 | Byte sent to the peripheral |
| periph_done | input | 1 | Peripheral finished the current byte |
| periph_err | input | 1 | The finished byte failed |
| periph_rdata | input | 8 | Byte returned by the peripheral |

## Verification
The assertions assume a peripheral that raises `periph_done` only while `periph_req` is high, keeps it high for one cycle, and raises `periph_err` only together with done. They also assume a host that holds its request fields steady until acceptance. The bench's peripheral responder answers only an active request, after a fixed wait, with a one-cycle done. The host side changes its request only on the falling edge after acceptance and waits for each response before issuing the next request, so these assumptions hold throughout. The failure cases pick which byte index reports the error.

// File: rtl/epp_pkg.sv
package epp_pkg;
  localparam logic [2:0] OFS_STATUS = 3'd1;
  localparam logic [2:0] OFS_CTRL   = 3'd2;
  localparam logic [2:0] OFS_EADDR  = 3'd3;
  localparam logic [2:0] OFS_EDATA  = 3'd4;

  localparam logic [7:0] CTRL_RESET = 8'hCC;
  localparam logic [7:0] CTRL_FIXED = 8'hC0;
  localparam logic [7:0] GATE_MASK  = 8'h2F;
  localparam logic [7:0] GATE_WR    = 8'h04;
  localparam logic [7:0] GATE_RD    = 8'h24;

  typedef enum logic [1:0] {ST_IDLE, ST_XFER, ST_RESP} eng_state_t;
endpackage

// File: rtl/epp_ctrl_reg.sv
module epp_ctrl_reg
  import epp_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       wr_en,
  input  logic [7:0] wr_val,
  output logic [7:0] ctrl,
  output logic       dir_chg,
  output logic       wr_ok,
  output logic       rd_ok
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl    <= CTRL_RESET;
      dir_chg <= 1'b0;
    end else begin
      dir_chg <= 1'b0;
      if (wr_en) begin
        ctrl    <= wr_val | CTRL_FIXED;
        dir_chg <= (wr_val[5] != ctrl[5]);
      end
    end
  end

  assign wr_ok = (ctrl & GATE_MASK) == GATE_WR;
  assign rd_ok = (ctrl & GATE_MASK) == GATE_RD;

  AST_CTRL_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> (ctrl[5:0] == $past(wr_val[5:0])) && (ctrl[7:6] == 2'b11)); // R2
  AST_DIR_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    dir_chg |-> (ctrl[5] != $past(ctrl[5]))); // R10
endmodule

// File: rtl/epp_timeout_flag.sv
module epp_timeout_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  output logic flag
);
  always_ff @(posedge clk) begin
    if (!rst_n)   flag <= 1'b0;
    else if (set) flag <= 1'b1;
    else if (clr) flag <= 1'b0;
  end

  AST_TMO_SET: assert property (@(posedge clk) disable iff (!rst_n)
    set |=> flag); // R6
  AST_TMO_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !clr) |=> flag); // R6
endmodule

// File: rtl/epp_byte_seq.sv
module epp_byte_seq #(
  parameter int MAX_BYTES = 4,
  localparam int CNT_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int DW    = 8 * MAX_BYTES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_write,
  input  logic             is_addr,
  input  logic [CNT_W-1:0] last_idx,
  input  logic [DW-1:0]    wdata,
  output logic             finish,
  output logic             fail,
  output logic [DW-1:0]    rbuf,
  output logic             periph_req,
  output logic             periph_write,
  output logic             periph_addr_cyc,
  output logic [7:0]       periph_wdata,
  input  logic             periph_done,
  input  logic             periph_err,
  input  logic [7:0]       periph_rdata
);
  logic             active;
  logic [CNT_W-1:0] idx;
  logic [CNT_W-1:0] last_q;
  logic [DW-1:0]    wbuf;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active          <= 1'b0;
      idx             <= '0;
      last_q          <= '0;
      wbuf            <= '0;
      rbuf            <= '1;
      periph_write    <= 1'b0;
      periph_addr_cyc <= 1'b0;
      finish          <= 1'b0;
      fail            <= 1'b0;
    end else begin
      finish <= 1'b0;
      fail   <= 1'b0;
      if (start) begin
        active          <= 1'b1;
        idx             <= '0;
        last_q          <= last_idx;
        wbuf            <= wdata;
        rbuf            <= '1;
        periph_write    <= is_write;
        periph_addr_cyc <= is_addr;
      end else if (active && periph_done) begin
        if (periph_err) begin
          fail   <= 1'b1;
          finish <= 1'b1;
          active <= 1'b0;
        end else begin
          if (!periph_write) rbuf[int'(idx)*8 +: 8] <= periph_rdata;
          if (idx == last_q) begin
            finish <= 1'b1;
            active <= 1'b0;
          end else begin
            idx <= idx + 1'b1;
          end
        end
      end
    end
  end

  assign periph_req   = active;
  assign periph_wdata = wbuf[int'(idx)*8 +: 8];

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_req && !periph_done) |=> periph_req && $stable(periph_wdata) && $stable(periph_write)); // R11
  AST_FAIL_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> !periph_req); // R8
endmodule

// File: rtl/epp_cycle_engine.sv
module epp_cycle_engine
  import epp_pkg::*;
#(
  parameter int MAX_BYTES = 4,
  localparam int CNT_W = (MAX_BYTES > 1) ? $clog2(MAX_BYTES) : 1,
  localparam int DW    = 8 * MAX_BYTES
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          host_req_valid,
  output logic          host_req_ready,
  input  logic          host_req_write,
  input  logic [2:0]    host_req_offset,
  input  logic [1:0]    host_req_size,
  input  logic [DW-1:0] host_req_wdata,
  output logic          host_rsp_valid,
  output logic [DW-1:0] host_rsp_rdata,
  output logic [7:0]    ctrl_out,
  input  logic [7:0]    periph_status,
  output logic          timeout_flag,
  output logic          periph_dir_chg,
  output logic          periph_dir,
  output logic          periph_req,
  output logic          periph_write,
  output logic          periph_addr_cyc,
  output logic [7:0]    periph_wdata,
  input  logic          periph_done,
  input  logic          periph_err,
  input  logic [7:0]    periph_rdata
);
  eng_state_t       state;
  logic [DW-1:0]    rsp_q;
  logic             accept, is_epp, gate_ok;
  logic             seq_start, ctrl_wr, tmo_clr;
  logic             wr_ok, rd_ok, seq_finish, seq_fail;
  logic [DW-1:0]    seq_rbuf;
  logic [CNT_W-1:0] last_idx;

  assign accept    = host_req_valid && (state == ST_IDLE);
  assign is_epp    = (host_req_offset == OFS_EADDR) || (host_req_offset == OFS_EDATA);
  assign gate_ok   = host_req_write ? wr_ok : rd_ok;
  assign seq_start = accept && is_epp && gate_ok;
  assign ctrl_wr   = accept && host_req_write && (host_req_offset == OFS_CTRL);
  assign tmo_clr   = accept && host_req_write && (host_req_offset == OFS_STATUS)
                     && host_req_wdata[0];

  always_comb begin
    int nb;
    nb = 1 << host_req_size;
    if (nb > MAX_BYTES) nb = MAX_BYTES;
    if (host_req_offset == OFS_EADDR) nb = 1;
    last_idx = CNT_W'(nb - 1);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state <= ST_IDLE;
      rsp_q <= '1;
    end else begin
      case (state)
        ST_IDLE: if (accept) begin
          rsp_q <= '1;
          state <= ST_RESP;
          if (seq_start) begin
            state <= ST_XFER;
          end else if (!host_req_write && host_req_offset == OFS_STATUS) begin
            rsp_q[7:0] <= {periph_status[7:1], timeout_flag};
          end else if (!host_req_write && host_req_offset == OFS_CTRL) begin
            rsp_q[7:0] <= ctrl_out;
          end
        end
        ST_XFER: if (seq_finish) begin
          rsp_q <= periph_write ? '1 : seq_rbuf;
          state <= ST_RESP;
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign host_req_ready = (state == ST_IDLE);
  assign host_rsp_valid = (state == ST_RESP);
  assign host_rsp_rdata = rsp_q;
  assign periph_dir     = ctrl_out[5];

  epp_ctrl_reg i_ctrl (
    .clk(clk), .rst_n(rst_n), .wr_en(ctrl_wr), .wr_val(host_req_wdata[7:0]),
    .ctrl(ctrl_out), .dir_chg(periph_dir_chg), .wr_ok(wr_ok), .rd_ok(rd_ok)
  );

  epp_timeout_flag i_tmo (
    .clk(clk), .rst_n(rst_n), .set(seq_fail), .clr(tmo_clr), .flag(timeout_flag)
  );

  epp_byte_seq #(.MAX_BYTES(MAX_BYTES)) i_seq (
    .clk(clk), .rst_n(rst_n), .start(seq_start), .is_write(host_req_write),
    .is_addr(host_req_offset == OFS_EADDR), .last_idx(last_idx),
    .wdata(host_req_wdata), .finish(seq_finish), .fail(seq_fail), .rbuf(seq_rbuf),
    .periph_req(periph_req), .periph_write(periph_write),
    .periph_addr_cyc(periph_addr_cyc), .periph_wdata(periph_wdata),
    .periph_done(periph_done), .periph_err(periph_err), .periph_rdata(periph_rdata)
  );

  AST_IDLE_NO_REQ: assert property (@(posedge clk) disable iff (!rst_n)
    host_req_ready |-> !periph_req); // R9
  AST_RSP_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    host_rsp_valid |=> host_req_ready); // R9
  AST_WR_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_req && periph_write) |-> ((ctrl_out & GATE_MASK) == GATE_WR)); // R3
  AST_RD_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (periph_req && !periph_write) |-> ((ctrl_out & GATE_MASK) == GATE_RD)); // R4
endmodule

// File: tb/test_epp_cycle_engine.sv
module test_epp_cycle_engine;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        host_req_valid = 1'b0;
  logic        host_req_ready;
  logic        host_req_write = 1'b0;
  logic [2:0]  host_req_offset = '0;
  logic [1:0]  host_req_size = '0;
  logic [31:0] host_req_wdata = '0;
  logic        host_rsp_valid;
  logic [31:0] host_rsp_rdata;
  logic [7:0]  ctrl_out;
  logic [7:0]  periph_status = 8'h5A;
  logic        timeout_flag, periph_dir_chg, periph_dir;
  logic        periph_req, periph_write, periph_addr_cyc;
  logic [7:0]  periph_wdata;
  logic        periph_done = 1'b0;
  logic        periph_err = 1'b0;
  logic [7:0]  periph_rdata = 8'h00;

  always #4 clk = ~clk;

  epp_cycle_engine i_epp_cycle_engine (.*);

  int checks = 0;
  int errors = 0;
  logic [7:0] m_ctrl = 8'hCC;
  logic       m_tmo = 1'b0;
  bit         m_expect_xfer = 0;
  int         err_at_g = -1;
  int         bidx = 0;
  int         wcnt = 0;
  int         dir_pulses = 0;
  logic       last_dir = 1'b0;
  logic [7:0] byte_log[$];
  logic       addr_log[$];
  logic       wr_log[$];
  logic       prev_req = 1'b0, prev_done = 1'b0;
  logic [7:0] prev_wdata = '0;
  int         cycles = 0;
  localparam int LAT = 2;

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // per-clock monitor, model compare and peripheral responder
  always @(negedge clk) begin
    if (rst_n) begin
      if (host_req_ready) begin
        chk("R2", "ctrl_out vs model", {24'h0, ctrl_out}, {24'h0, m_ctrl});
        chk("R6", "timeout vs model", {31'h0, timeout_flag}, {31'h0, m_tmo});
      end
      if (periph_req && !m_expect_xfer) chk("R3", "unexpected periph_req", 1, 0);
      if (prev_req && !prev_done) begin
        chk("R11", "req held", {31'h0, periph_req}, 1);
        chk("R11", "wdata held", {24'h0, periph_wdata}, {24'h0, prev_wdata});
      end
      if (periph_dir_chg) begin
        dir_pulses++;
        last_dir = periph_dir;
      end
      if (periph_done) begin
        periph_done = 1'b0;
        periph_err  = 1'b0;
        wcnt = 0;
      end else if (periph_req) begin
        wcnt++;
        if (wcnt == LAT) begin
          periph_done  = 1'b1;
          periph_err   = (bidx == err_at_g);
          periph_rdata = 8'hA0 + 8'(bidx);
          byte_log.push_back(periph_wdata);
          addr_log.push_back(periph_addr_cyc);
          wr_log.push_back(periph_write);
          bidx++;
        end
      end
      prev_req   = periph_req;
      prev_wdata = periph_wdata;
      prev_done  = periph_done;
    end
  end

  task automatic acc(input logic wr, input logic [2:0] ofs, input logic [1:0] sz,
                     input logic [31:0] wd, input int err_at, input string tag);
    logic [31:0] exp;
    logic [7:0]  old_ctrl;
    int nb, exp_bytes, n;
    bit xfer, fails;
    old_ctrl = m_ctrl;
    nb = (ofs == 3'd3) ? 1 : (1 << sz);
    if (nb > 4) nb = 4;
    xfer = (ofs == 3'd3 || ofs == 3'd4) &&
           (wr ? ((m_ctrl & 8'h2F) == 8'h04) : ((m_ctrl & 8'h2F) == 8'h24));
    fails = xfer && err_at >= 0 && err_at < nb;
    exp_bytes = !xfer ? 0 : (fails ? err_at + 1 : nb);
    exp = '1;
    if (!wr) begin
      if (ofs == 3'd1) exp[7:0] = {periph_status[7:1], m_tmo};
      else if (ofs == 3'd2) exp[7:0] = m_ctrl;
      else if (xfer)
        for (int k = 0; k < nb; k++)
          if (err_at < 0 || k < err_at) exp[8*k +: 8] = 8'hA0 + 8'(k);
    end
    byte_log.delete(); addr_log.delete(); wr_log.delete();
    bidx = 0; err_at_g = err_at; m_expect_xfer = xfer; dir_pulses = 0;
    @(negedge clk);
    host_req_valid = 1'b1; host_req_write = wr; host_req_offset = ofs;
    host_req_size = sz; host_req_wdata = wd;
    chk(tag, "ready before request", {31'h0, host_req_ready}, 1);
    @(posedge clk);
    @(negedge clk);
    host_req_valid = 1'b0;
    n = 0;
    while (!host_rsp_valid && n < 100) begin @(negedge clk); n++; end
    chk(tag, "response seen", {31'h0, host_rsp_valid}, 1);
    chk("R9", "ready low at response", {31'h0, host_req_ready}, 0);
    chk(tag, "rdata", host_rsp_rdata, exp);
    if (wr && ofs == 3'd2) m_ctrl = wd[7:0] | 8'hC0;
    if (wr && ofs == 3'd1 && wd[0]) m_tmo = 1'b0;
    if (fails) m_tmo = 1'b1;
    m_expect_xfer = 0;
    @(negedge clk);
    chk("R9", "one-cycle response", {31'h0, host_rsp_valid}, 0);
    chk("R9", "ready after response", {31'h0, host_req_ready}, 1);
    chk(tag, "byte count", byte_log.size(), exp_bytes);
    for (int k = 0; k < byte_log.size(); k++) begin
      if (wr) chk("R5", "wire byte order", {24'h0, byte_log[k]}, {24'h0, wd[8*k +: 8]});
      chk("R5", "address-cycle flag", {31'h0, addr_log[k]}, {31'h0, ofs == 3'd3});
      chk("R5", "direction flag", {31'h0, wr_log[k]}, {31'h0, wr});
    end
    if (wr && ofs == 3'd2) begin
      chk("R10", "dir pulses", dir_pulses, (wd[5] != old_ctrl[5]) ? 1 : 0);
      if (dir_pulses > 0) chk("R10", "new dir", {31'h0, last_dir}, {31'h0, wd[5]});
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 20000) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  logic [31:0] dummy;
  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "ready after reset", {31'h0, host_req_ready}, 1);
    chk("R1", "timeout after reset", {31'h0, timeout_flag}, 0);
    chk("R1", "ctrl after reset", {24'h0, ctrl_out}, 32'h0000_00CC);
    acc(0, 3'd2, 2'd0, 0, -1, "R1");                 // control read 0xFFFFFFCC
    acc(0, 3'd4, 2'd2, 0, -1, "R4");                 // 0xCC: read gated off
    acc(1, 3'd4, 2'd2, 32'h1122_3344, -1, "R3");     // 0xCC: write gated off
    acc(1, 3'd2, 2'd0, 32'h0000_0004, -1, "R2");     // -> 0xC4, no dir change
    acc(0, 3'd2, 2'd0, 0, -1, "R2");
    acc(1, 3'd3, 2'd2, 32'hDEAD_BE5A, -1, "R5");     // address port: one byte
    acc(1, 3'd4, 2'd2, 32'h1122_3344, -1, "R5");     // 4 bytes
    acc(1, 3'd4, 2'd1, 32'hAABB_CCDD, -1, "R5");     // 2 bytes
    acc(1, 3'd4, 2'd0, 32'h0000_0077, -1, "R5");     // 1 byte
    acc(1, 3'd4, 2'd3, 32'h8899_AABB, -1, "R5");     // code 3 -> 4 bytes
    acc(0, 3'd3, 2'd0, 0, -1, "R4");                 // read gated off at 0xC4
    acc(1, 3'd2, 2'd0, 32'h0000_0024, -1, "R10");    // dir change
    acc(0, 3'd4, 2'd2, 0, -1, "R5");                 // 0xA3A2A1A0
    acc(0, 3'd4, 2'd1, 0, -1, "R5");
    acc(0, 3'd3, 2'd2, 0, -1, "R5");                 // address read 1 byte
    acc(1, 3'd4, 2'd2, 32'h1234_5678, -1, "R3");     // write gated off at 0xE4
    acc(0, 3'd1, 2'd0, 0, -1, "R6");                 // status, flag clear
    acc(0, 3'd4, 2'd2, 0, 2, "R8");                  // fail at byte 2
    acc(0, 3'd1, 2'd0, 0, -1, "R6");                 // flag now shown
    acc(0, 3'd4, 2'd0, 0, -1, "R6");                 // good read keeps flag
    acc(1, 3'd1, 2'd0, 32'hFFFF_FFFE, -1, "R7");     // bit0 clear: no effect
    acc(0, 3'd1, 2'd0, 0, -1, "R7");
    acc(1, 3'd1, 2'd0, 32'h0000_0001, -1, "R7");     // clears
    acc(0, 3'd1, 2'd0, 0, -1, "R7");
    acc(1, 3'd2, 2'd0, 32'h0000_002C, -1, "R10");    // select set, no dir change
    acc(0, 3'd4, 2'd2, 0, -1, "R4");                 // gated off
    acc(1, 3'd2, 2'd0, 32'h0000_0004, -1, "R10");    // back to write pattern
    acc(1, 3'd4, 2'd2, 32'hCAFE_F00D, 1, "R8");      // fail at byte 1
    acc(1, 3'd4, 2'd2, 32'h0BAD_F00D, 0, "R8");      // fail at first byte
    acc(1, 3'd1, 2'd0, 32'h0000_0001, -1, "R7");
    periph_status = 8'hA3;
    acc(0, 3'd1, 2'd0, 0, -1, "R6");
    acc(0, 3'd6, 2'd0, 0, -1, "R9");                 // unused offset
    dummy = host_rsp_rdata;
    repeat (4) @(negedge clk);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule